// File: doc/BRIEF.md
# Video Output Rounding and Format Stage

This stage sits at the tail of a video output pipeline. It receives three component channels that still carry fractional bits from upstream arithmetic. It rounds each channel to a 10-bit word and chooses the number coding of each word. Channel 0 carries luma, or green in RGB operation. Channels 1 and 2 carry the two colour-difference components, or blue and red. The results are registered once, and a valid flag travels with the data.

A rounding control selects between two modes. In full-precision mode the result is rounded to the 10-bit grid. In reduced mode the result is rounded to the 8-bit grid while the word stays 10 bits wide, so its two lowest bits read zero. A coding control selects two's complement or offset binary for the colour-difference channels. A separate RGB indication, tied to the same control as the upstream matrix enable, makes all three channels unsigned and overrides the coding control. Every rounding saturates at the top code of its mode instead of wrapping.

Top module: `vfmt_out_stage`

## Requirements
- R1: With `rnd_full` high, each output equals the input (12 bits, 2 fraction bits) rounded half-up to the 10-bit grid, i.e. floor((v + 2) / 4).
- R2: With `rnd_full` low, each output equals 4 * floor((v + 8) / 16), meaning a rounding bit is added at output bit 1 and output bits 1 and 0 are then zero.
- R3: An unsigned channel whose rounding would pass the top code saturates at 0x3FF (full mode) or 0x3FC (reduced mode).
- R4: With `rgb_mode` low, channels 1 and 2 are two's complement inputs. A positive overflow saturates at +511 (0x1FF) in full mode or +508 (0x1FC) in reduced mode. Negative values round half-up, toward plus infinity.
- R5: With `rgb_mode` low and `chroma_signed` high, channels 1 and 2 come out in two's complement.
- R6: With `rgb_mode` low and `chroma_signed` low, channels 1 and 2 come out as offset binary: the two's complement result with output bit 9 inverted.
- R7: With `rgb_mode` high, all three inputs are unsigned and all three outputs are offset binary (no bit inverted), whatever `chroma_signed` is.
- R8: Channel 0 is always treated as unsigned and is never affected by `chroma_signed`.
- R9: `out_valid` equals `in_valid` one clock earlier. The data outputs load only on a clock where `in_valid` is high and hold their value otherwise.
- R10: While `rst_n` is low, `out_valid` and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ch0 | input | 12 | Luma / green, unsigned, 2 fraction bits |
| in_ch1 | input | 12 | Blue-difference / blue, 2 fraction bits |
| in_ch2 | input | 12 | Red-difference / red, 2 fraction bits |
| rnd_full | input | 1 | 1: round to 10 bits, 0: round to 8 bits |
| chroma_signed | input | 1 | 1: channels 1 and 2 out as two's complement |
| rgb_mode | input | 1 | 1: all channels unsigned, offset binary out |
| out_valid | output | 1 | Output valid |
| out_ch0 | output | 10 | Channel 0 result |
| out_ch1 | output | 10 | Channel 1 result |
| out_ch2 | output | 10 | Channel 2 result |

## Verification
The only state is the output register and the valid flag. A fault there shows at the ports on the clock edge after the sample that should have loaded: a stale word, a flag out of step, or a word changing while `in_valid` is low. Faults in the rounding and coding paths show on the first sample that reaches the affected code. The checks to watch are codes just below and at a saturation limit, negative colour-difference values, and reduced-mode words with nonzero low bits. Each control combination is applied against a model computed in the bench, so a wrong sign treatment or a wrong bit inversion appears within one sample.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

    // Number of component channels handled by the stage
    localparam int NUM_CH = 3;

    // Channel roles; index 0 is always the unsigned luma / green path
    typedef enum logic [1:0] {
        CH_LUMA = 2'd0,
        CH_CB   = 2'd1,
        CH_CR   = 2'd2
    } chan_e;

    // Rounding precision selection
    typedef enum logic {
        RND_REDUCED = 1'b0,
        RND_FULL    = 1'b1
    } rnd_mode_e;

endpackage

// File: rtl/vfmt_round.sv
module vfmt_round #(
    parameter int DATA_W = 10,
    parameter int FRAC_W = 2,
    localparam int IN_W  = DATA_W + FRAC_W
) (
    input  logic [IN_W-1:0]   din,
    input  logic              is_signed,
    input  logic              full_prec,
    output logic [DATA_W-1:0] dout
);

    logic [IN_W:0]     inc;
    logic [IN_W:0]     sum;
    logic              ovf;
    logic [DATA_W-1:0] trunc;
    logic [DATA_W-1:0] sat;
    logic [DATA_W-1:0] pick;

    always_comb begin
        // half of the discarded LSB weight, for the selected grid
        inc = '0;
        if (full_prec) begin
            inc[FRAC_W-1] = 1'b1;
        end else begin
            inc[FRAC_W+1] = 1'b1;
        end

        sum   = {is_signed & din[IN_W-1], din} + inc;
        trunc = sum[IN_W-1:FRAC_W];

        // only an upward carry can overflow: increment is positive
        if (is_signed) begin
            ovf = ~din[IN_W-1] & sum[IN_W-1];
            sat = {1'b0, {(DATA_W-1){1'b1}}};
        end else begin
            ovf = sum[IN_W];
            sat = '1;
        end

        pick = ovf ? sat : trunc;
        if (!full_prec) begin
            pick[1:0] = 2'b00;
        end
        dout = pick;
    end

endmodule

// File: rtl/vfmt_code.sv
module vfmt_code #(
    parameter int DATA_W = 10
) (
    input  logic [DATA_W-1:0] din,
    input  logic              to_offset,
    output logic [DATA_W-1:0] dout
);

    always_comb begin
        dout = din;
        dout[DATA_W-1] = din[DATA_W-1] ^ to_offset;
    end

endmodule

// File: rtl/vfmt_out_stage.sv
module vfmt_out_stage #(
    parameter int DATA_W = 10,
    parameter int FRAC_W = 2,
    localparam int IN_W  = DATA_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_ch0,
    input  logic [IN_W-1:0]   in_ch1,
    input  logic [IN_W-1:0]   in_ch2,
    input  logic              rnd_full,
    input  logic              chroma_signed,
    input  logic              rgb_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_ch0,
    output logic [DATA_W-1:0] out_ch1,
    output logic [DATA_W-1:0] out_ch2
);
    import vfmt_pkg::*;

    logic [IN_W-1:0]   din_a   [NUM_CH];
    logic [DATA_W-1:0] rnd_a   [NUM_CH];
    logic [DATA_W-1:0] coded_a [NUM_CH];
    logic [DATA_W-1:0] q_a     [NUM_CH];
    logic              valid_q;

    assign din_a[CH_LUMA] = in_ch0;
    assign din_a[CH_CB]   = in_ch1;
    assign din_a[CH_CR]   = in_ch2;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic ch_signed;
        logic ch_offset;

        if (c == int'(CH_LUMA)) begin : g_luma
            assign ch_signed = 1'b0;
            assign ch_offset = 1'b0;
        end else begin : g_chroma
            assign ch_signed = ~rgb_mode;
            assign ch_offset = ~rgb_mode & ~chroma_signed;
        end

        vfmt_round #(
            .DATA_W (DATA_W),
            .FRAC_W (FRAC_W)
        ) i_round (
            .din       (din_a[c]),
            .is_signed (ch_signed),
            .full_prec (rnd_full),
            .dout      (rnd_a[c])
        );

        vfmt_code #(
            .DATA_W (DATA_W)
        ) i_code (
            .din       (rnd_a[c]),
            .to_offset (ch_offset),
            .dout      (coded_a[c])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_a[c] <= '0;
            end else if (in_valid) begin
                q_a[c] <= coded_a[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
        end
    end

    assign out_valid = valid_q;
    assign out_ch0   = q_a[CH_LUMA];
    assign out_ch1   = q_a[CH_CB];
    assign out_ch2   = q_a[CH_CR];

endmodule

// File: rtl/vfmt_out_chk.sv
module vfmt_out_chk #(
    parameter int DATA_W = 10,
    parameter int FRAC_W = 2,
    localparam int IN_W  = DATA_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [IN_W-1:0]   in_ch0,
    input logic [IN_W-1:0]   in_ch1,
    input logic [IN_W-1:0]   in_ch2,
    input logic              rnd_full,
    input logic              chroma_signed,
    input logic              rgb_mode,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_ch0,
    input logic [DATA_W-1:0] out_ch1,
    input logic [DATA_W-1:0] out_ch2
);

    a_r9_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_ch0) && $stable(out_ch1) && $stable(out_ch2)));

    a_r2_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rnd_full) |=>
            (out_ch0[1:0] == 2'b00 && out_ch1[1:0] == 2'b00 && out_ch2[1:0] == 2'b00));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rnd_full && in_ch0 == {IN_W{1'b1}}) |=> (out_ch0 == {DATA_W{1'b1}}));

    a_r5_positive_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rgb_mode && chroma_signed && !in_ch1[IN_W-1]) |=> !out_ch1[DATA_W-1]);

    a_r6_offset_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rgb_mode && !chroma_signed && !in_ch2[IN_W-1]) |=> out_ch2[DATA_W-1]);

    a_r7_rgb_top: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rgb_mode && rnd_full && in_ch1 == {IN_W{1'b1}}) |=> (out_ch1 == {DATA_W{1'b1}}));

endmodule

bind vfmt_out_stage vfmt_out_chk #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W)
) i_vfmt_out_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ch0        (in_ch0),
    .in_ch1        (in_ch1),
    .in_ch2        (in_ch2),
    .rnd_full      (rnd_full),
    .chroma_signed (chroma_signed),
    .rgb_mode      (rgb_mode),
    .out_valid     (out_valid),
    .out_ch0       (out_ch0),
    .out_ch1       (out_ch1),
    .out_ch2       (out_ch2)
);

// File: tb/test_vfmt_out_stage.sv
module test_vfmt_out_stage;

    localparam int DW = 10;
    localparam int FW = 2;
    localparam int IW = DW + FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_ch0 = '0;
    logic [IW-1:0] in_ch1 = '0;
    logic [IW-1:0] in_ch2 = '0;
    logic          rnd_full = 1'b1;
    logic          chroma_signed = 1'b1;
    logic          rgb_mode = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_ch0;
    logic [DW-1:0] out_ch1;
    logic [DW-1:0] out_ch2;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    vfmt_out_stage #(.DATA_W(DW), .FRAC_W(FW)) i_vfmt_out_stage (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ch0        (in_ch0),
        .in_ch1        (in_ch1),
        .in_ch2        (in_ch2),
        .rnd_full      (rnd_full),
        .chroma_signed (chroma_signed),
        .rgb_mode      (rgb_mode),
        .out_valid     (out_valid),
        .out_ch0       (out_ch0),
        .out_ch1       (out_ch1),
        .out_ch2       (out_ch2)
    );

    // Expected result from the requirement formulas
    function automatic int model(int raw, bit sgn, bit full, bit to_off);
        int v;
        int r;
        int top;
        v = (sgn && raw >= (1 << (IW - 1))) ? raw - (1 << IW) : raw;
        if (full) begin
            r   = (v + 2) >>> 2;
            top = sgn ? 511 : 1023;
        end else begin
            r   = ((v + 8) >>> 4) * 4;
            top = sgn ? 508 : 1020;
        end
        if (r > top) r = top;
        r = r & 1023;
        if (to_off) r = r ^ 512;
        return r;
    endfunction

    task automatic check(string req, int got, int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Apply one sample, wait one edge, compare all channels
    task automatic apply(string req, int a, int b, int c, bit full, bit sgn_out, bit rgb);
        @(negedge clk);
        in_ch0 = a[IW-1:0]; in_ch1 = b[IW-1:0]; in_ch2 = c[IW-1:0];
        rnd_full = full; chroma_signed = sgn_out; rgb_mode = rgb;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check(req, int'(out_valid), 1);
        check(req, int'(out_ch0), model(a, 1'b0, full, 1'b0));
        check(req, int'(out_ch1), model(b, !rgb, full, !rgb && !sgn_out));
        check(req, int'(out_ch2), model(c, !rgb, full, !rgb && !sgn_out));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10", int'(out_valid), 0);
        check("R10", int'(out_ch0), 0);
        check("R10", int'(out_ch1), 0);
        check("R10", int'(out_ch2), 0);
    endtask

    task automatic t_round_full();
        apply("R1", 'h005, 'h006, 'h007, 1'b1, 1'b1, 1'b0);
        check("R1", int'(out_ch0), 'h001);
        apply("R1", 'h7FE, 'h001, 'h002, 1'b1, 1'b1, 1'b0);
        check("R1", int'(out_ch0), 'h200);
    endtask

    task automatic t_round_reduced();
        apply("R2", 'h017, 'h018, 'h027, 1'b0, 1'b1, 1'b0);
        check("R2", int'(out_ch0), 'h004);
        check("R2", int'(out_ch1), 'h008);
    endtask

    task automatic t_saturate();
        apply("R3", 'hFFF, 'h7FF, 'h7FD, 1'b1, 1'b1, 1'b0);
        check("R3", int'(out_ch0), 'h3FF);
        check("R4", int'(out_ch1), 'h1FF);
        apply("R3", 'hFFF, 'h7FF, 'h7F7, 1'b0, 1'b1, 1'b0);
        check("R3", int'(out_ch0), 'h3FC);
        check("R4", int'(out_ch1), 'h1FC);
    endtask

    task automatic t_chroma_coding();
        apply("R5", 'h100, 'hF00, 'hFFF, 1'b1, 1'b1, 1'b0);
        check("R5", int'(out_ch1), 'h3C0);
        check("R4", int'(out_ch2), 'h000);
        apply("R6", 'h100, 'hF00, 'h7FF, 1'b1, 1'b0, 1'b0);
        check("R6", int'(out_ch1), 'h1C0);
        check("R6", int'(out_ch2), 'h3FF);
    endtask

    task automatic t_rgb();
        apply("R7", 'h800, 'hFFF, 'h800, 1'b1, 1'b1, 1'b1);
        check("R7", int'(out_ch1), 'h3FF);
        check("R7", int'(out_ch2), 'h200);
        apply("R7", 'h800, 'hFFF, 'h800, 1'b1, 1'b0, 1'b1);
        check("R7", int'(out_ch1), 'h3FF);
        check("R7", int'(out_ch2), 'h200);
    endtask

    task automatic t_luma();
        apply("R8", 'h800, 'h000, 'h000, 1'b1, 1'b1, 1'b0);
        check("R8", int'(out_ch0), 'h200);
        apply("R8", 'h800, 'h000, 'h000, 1'b1, 1'b0, 1'b0);
        check("R8", int'(out_ch0), 'h200);
    endtask

    task automatic t_hold();
        apply("R9", 'h123, 'h456, 'hABC, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        in_ch0 = 'hFFF; in_ch1 = 'h000; in_ch2 = 'h7FF;
        @(posedge clk);
        #1;
        check("R9", int'(out_valid), 0);
        check("R9", int'(out_ch0), model('h123, 1'b0, 1'b1, 1'b0));
        check("R9", int'(out_ch1), model('h456, 1'b1, 1'b1, 1'b0));
        check("R9", int'(out_ch2), model('hABC, 1'b1, 1'b1, 1'b0));
    endtask

    task automatic t_sweep();
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 24; k++) begin
                int a = (k * 181 + m * 37) % 4096;
                int b = (k * 1237 + 5) % 4096;
                int c = 4095 - ((k * 389 + m) % 4096);
                apply("R1", a, b, c, m[0], m[1], m[2]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_round_full();
        t_round_reduced();
        t_saturate();
        t_chroma_coding();
        t_rgb();
        t_luma();
        t_hold();
        t_sweep();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule